// File: doc/BRIEF.md
# Bus Protection Handshake Controller

This controller owns a bank of fence bits, one per interconnect port, that stop traffic into a power domain before that domain is switched off and release it after the domain is back. A requester hands over a bit mask and a direction, either raise or drop. The controller rewrites only the masked fence bits. It then watches a separate acknowledge vector from the interconnect until every masked acknowledge bit agrees with the requested direction. It reports completion, or an error when the wait runs out.

A domain usually owns a small group of fence bits, up to four. Other bits in the bank belong to other domains and must never be disturbed by a request. The acknowledge vector is sampled once per clock. The wait limit is a parameter counted in clock cycles. Requests use a valid/ready handshake. The response is a single-cycle pulse that carries an error flag.

Top module: `bph_ctrl`

## Requirements
- R1: An accepted raise request (`req_set`=1) sets every fence bit whose mask bit is 1. All other fence bits keep their value. `fence_en` shows the new value from the cycle after acceptance.
- R2: An accepted drop request (`req_set`=0) clears every fence bit whose mask bit is 1. All other fence bits keep their value.
- R3: A raise request completes without error once every masked bit of `fence_ack` reads 1 at a clock edge.
- R4: A drop request completes without error once every masked bit of `fence_ack` reads 0 at a clock edge.
- R5: The acknowledge vector is compared at the TIMEOUT_CYC clock edges that follow acceptance. If none of those compares succeeds, the response carries `rsp_err`=1, and `rsp_done` is high exactly TIMEOUT_CYC cycles after the acceptance edge.
- R6: A successful compare at the last allowed edge takes priority over expiry, and the response then carries no error. In general, a compare that first succeeds at edge k+1 after acceptance gives `rsp_done` k+1 cycles after acceptance.
- R7: After a timeout the fence bits keep the value written by the request. There is no rollback.
- R8: `req_ready` is 1 only while the controller is idle. A request is taken only at an edge where `req_valid` and `req_ready` are both 1. Changes to `req_valid`, `req_set` or `req_mask` while busy have no effect on `fence_en` or on the running operation.
- R9: `rsp_done` is high for exactly one cycle per accepted request. `rsp_err` is high only together with `rsp_done`. The controller is ready again in the cycle of the pulse.
- R10: After reset `fence_en` is all zero, `req_ready` is 1 and `rsp_done` is 0.
- R11: A request with an all-zero mask leaves `fence_en` unchanged. It completes without error one cycle after acceptance.
- R12: Acknowledge bits outside the mask are ignored by the compare, whatever their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_set | input | 1 | 1 raises the masked fence bits, 0 drops them |
| req_mask | input | WIDTH | Fence bits addressed by the request |
| fence_ack | input | WIDTH | Per-port protection acknowledge from the interconnect |
| fence_en | output | WIDTH | Fence enable bank |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Wait expired, valid with rsp_done |

## Verification
A successful compare and the expiry of the wait counter can occur at the same clock edge. The bench provokes this by delaying the modelled acknowledge so that it settles exactly at the last allowed compare, and expects a response without error. A second run delays the acknowledge by one more cycle and expects an error at the same latency. A second overlap is the completion pulse and the next acceptance, which the bench makes coincide by offering a new request in the pulse cycle. The bench then checks that the second operation starts from the fence value left by the first.

// File: rtl/bph_pkg.sv
package bph_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } bph_state_e;

  typedef enum logic [0:0] {
    OP_DROP  = 1'b0,
    OP_RAISE = 1'b1
  } bph_op_e;

endpackage

// File: rtl/bph_enable_bank.sv
module bph_enable_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             op_raise,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] en_q
);

  logic [WIDTH-1:0] en_d;

  // per-bit next value: masked bits take the direction, others hold
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign en_d[b] = (upd && mask[b]) ? op_raise : en_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (upd) begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/bph_match.sv
module bph_match #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] ack,
  input  logic [WIDTH-1:0] mask,
  input  logic             op_raise,
  output logic             hit
);

  logic [WIDTH-1:0] bit_ok;

  // an unmasked bit always agrees; a masked bit must equal the direction
  for (genvar b = 0; b < WIDTH; b++) begin : g_cmp
    assign bit_ok[b] = ~mask[b] | (ack[b] == op_raise);
  end

  assign hit = &bit_ok;

endmodule

// File: rtl/bph_timer.sv
module bph_timer #(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic last
);

  localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | run;
    cnt_d  = clr ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/bph_seq.sv
module bph_seq
  import bph_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_set,
  input  logic [WIDTH-1:0] req_mask,
  input  logic             hit,
  input  logic             tmr_last,
  output logic             idle,
  output logic             accept,
  output logic             tmr_clr,
  output logic             tmr_run,
  output logic             op_raise_q,
  output logic [WIDTH-1:0] mask_q,
  output logic             done_q,
  output logic             err_q
);

  bph_state_e state_q, state_d;
  logic       done_d, err_d;

  assign idle   = (state_q == ST_IDLE);
  assign accept = idle & req_valid;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    tmr_clr = 1'b0;
    tmr_run = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_WAIT;
          tmr_clr = 1'b1;
        end
      end
      ST_WAIT: begin
        if (hit) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (tmr_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
        end else begin
          tmr_run = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_raise_q <= 1'b0;
      mask_q     <= '0;
    end else if (accept) begin
      op_raise_q <= req_set;
      mask_q     <= req_mask;
    end
  end

endmodule

// File: rtl/bph_ctrl.sv
module bph_ctrl #(
  parameter int WIDTH       = 32,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_set,
  input  logic [WIDTH-1:0] req_mask,
  input  logic [WIDTH-1:0] fence_ack,
  output logic [WIDTH-1:0] fence_en,
  output logic             rsp_done,
  output logic             rsp_err
);

  logic             rst_meta_q, rst_sync_n;
  logic             idle, accept, hit, tmr_last, tmr_clr, tmr_run;
  logic             op_raise_q;
  logic [WIDTH-1:0] mask_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  bph_seq #(.WIDTH(WIDTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .req_set    (req_set),
    .req_mask   (req_mask),
    .hit        (hit),
    .tmr_last   (tmr_last),
    .idle       (idle),
    .accept     (accept),
    .tmr_clr    (tmr_clr),
    .tmr_run    (tmr_run),
    .op_raise_q (op_raise_q),
    .mask_q     (mask_q),
    .done_q     (rsp_done),
    .err_q      (rsp_err)
  );

  bph_enable_bank #(.WIDTH(WIDTH)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .upd      (accept),
    .op_raise (req_set),
    .mask     (req_mask),
    .en_q     (fence_en)
  );

  bph_match #(.WIDTH(WIDTH)) u_match (
    .ack      (fence_ack),
    .mask     (mask_q),
    .op_raise (op_raise_q),
    .hit      (hit)
  );

  bph_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .last  (tmr_last)
  );

  assign req_ready = idle;

endmodule

// File: rtl/bph_ctrl_chk.sv
module bph_ctrl_chk #(
  parameter int WIDTH       = 32,
  parameter int TIMEOUT_CYC = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_set,
  input logic [WIDTH-1:0] req_mask,
  input logic [WIDTH-1:0] fence_en,
  input logic             rsp_done,
  input logic             rsp_err
);

  logic        acc;
  logic [31:0] busy_cnt;

  assign acc = req_valid & req_ready;

  // cycles since the last acceptance, counted while busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (acc) begin
      busy_cnt <= '0;
    end else if (!req_ready) begin
      busy_cnt <= busy_cnt + 32'd1;
    end
  end

  p_raise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_set) |=> fence_en == ($past(fence_en) | $past(req_mask)));

  p_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_set) |=> fence_en == ($past(fence_en) & ~$past(req_mask)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(fence_en));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);

  p_ready_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (busy_cnt >= 32'd1) && (busy_cnt <= 32'(TIMEOUT_CYC)));

  p_err_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> busy_cnt == 32'(TIMEOUT_CYC));

endmodule

bind bph_ctrl bph_ctrl_chk #(.WIDTH(WIDTH), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_set   (req_set),
  .req_mask  (req_mask),
  .fence_en  (fence_en),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err)
);

// File: tb/bph_ctrl_tb_top.sv
module bph_ctrl_tb_top;

  localparam int W  = 32;
  localparam int TO = 16;
  localparam int HD = 32;

  typedef struct {
    logic         err;
    logic [W-1:0] en;
    int           lat;
    string        tag;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic         req_set;
  logic [W-1:0] req_mask;
  logic [W-1:0] fence_ack;
  logic [W-1:0] fence_en;
  logic         rsp_done;
  logic         rsp_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int t_acc  = 0;
  int dly    = 0;
  logic [W-1:0] stk1 = '0;
  logic [W-1:0] stk0 = '0;
  logic [W-1:0] exp_en = '0;
  logic [W-1:0] hist [HD];
  exp_t sb[$];

  bph_ctrl #(.WIDTH(W), .TIMEOUT_CYC(TO)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_set   (req_set),
    .req_mask  (req_mask),
    .fence_ack (fence_ack),
    .fence_en  (fence_en),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // interconnect model: acknowledge follows the fence bank after dly cycles
  initial for (int i = 0; i < HD; i++) hist[i] = '0;
  always @(posedge clk) begin
    hist[0] <= fence_en;
    for (int i = 1; i < HD; i++) hist[i] <= hist[i-1];
  end
  always_comb begin
    logic [W-1:0] base;
    base      = (dly == 0) ? fence_en : hist[dly-1];
    fence_ack = (base & ~stk0) | stk1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // index of the first successful compare, -1 when none within the limit
  function automatic int first_hit(input logic [W-1:0] old_en,
                                   input logic [W-1:0] new_en,
                                   input logic [W-1:0] m, input bit set);
    for (int k = 0; k < TO; k++) begin
      logic [W-1:0] e, s;
      e = (k >= dly) ? new_en : old_en;
      s = (e & ~stk0) | stk1;
      if (set ? ((s & m) == m) : ((s & m) == '0)) return k;
    end
    return -1;
  endfunction

  task automatic push_exp(input bit set, input logic [W-1:0] m, input string tag);
    logic [W-1:0] nx;
    int k;
    exp_t it;
    nx = set ? (exp_en | m) : (exp_en & ~m);
    k  = first_hit(exp_en, nx, m, set);
    it.err = (k < 0);
    it.en  = nx;
    it.lat = (k < 0) ? TO : k + 1;
    it.tag = tag;
    sb.push_back(it);
    exp_en = nx;
  endtask

  task automatic wait_empty();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic gap();
    repeat (HD + 2) @(negedge clk);
  endtask

  task automatic do_op(input bit set, input logic [W-1:0] m, input string tag,
                       input bit wait_done);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    push_exp(set, m, tag);
    req_valid = 1'b1;
    req_set   = set;
    req_mask  = m;
    @(posedge clk);
    #1 t_acc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    req_mask  = '0;
    if (wait_done) begin
      wait_empty();
      gap();
    end
  endtask

  // monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9 unexpected done", 64'(rsp_done), 64'd0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        chk(rsp_err == it.err, {it.tag, " err"}, 64'(rsp_err), 64'(it.err));
        chk(fence_en == it.en, {it.tag, " fence"}, 64'(fence_en), 64'(it.en));
        chk((cyc - t_acc) == it.lat, {it.tag, " latency"},
            64'(cyc - t_acc), 64'(it.lat));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_set   = 1'b0;
    req_mask  = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(fence_en == '0, "R10 fence reset", 64'(fence_en), 64'd0);
    chk(req_ready == 1'b1, "R10 ready reset", 64'(req_ready), 64'd1);
    chk(rsp_done == 1'b0, "R10 done reset", 64'(rsp_done), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R3 raise with acknowledge lagging two cycles
    dly = 2;
    do_op(1'b1, 32'h0000_000F, "R1 R3 raise low nibble", 1'b1);
    do_op(1'b1, 32'h0000_0030, "R1 raise keeps others", 1'b1);
    // R2 R4 drop part of the group
    do_op(1'b0, 32'h0000_0005, "R2 R4 drop", 1'b1);
    // R11 empty mask
    do_op(1'b1, 32'h0, "R11 empty mask", 1'b1);
    // R12 unmasked acknowledge bits are garbage
    dly  = 3;
    stk1 = 32'hFFFF_0000;
    do_op(1'b0, 32'h0000_0002, "R12 unmasked ignored", 1'b1);
    stk1 = '0;
    gap();
    // R6 success at the last compare beats expiry
    dly = TO - 1;
    do_op(1'b1, 32'h00F0_0000, "R6 last compare wins", 1'b1);
    // R5 R7 one cycle too late: timeout, no rollback
    dly = TO;
    do_op(1'b1, 32'h0F00_0000, "R5 R7 raise timeout", 1'b1);
    chk((fence_en & 32'h0F00_0000) == 32'h0F00_0000, "R7 no rollback",
        64'(fence_en), 64'(exp_en));
    // R5 drop that never sees its acknowledge clear
    dly  = 0;
    gap();
    stk1 = 32'h0000_0008;
    do_op(1'b0, 32'h0000_0008, "R5 drop timeout", 1'b1);
    stk1 = '0;
    gap();

    // R8 request changes while busy are ignored
    dly = 8;
    @(negedge clk);
    push_exp(1'b1, 32'h0000_1000, "R8 first request");
    req_valid = 1'b1;
    req_set   = 1'b1;
    req_mask  = 32'h0000_1000;
    @(posedge clk);
    #1 t_acc = cyc;
    @(negedge clk);
    req_set  = 1'b0;
    req_mask = 32'h0000_3008;
    for (int i = 0; i < 3; i++) begin
      chk(req_ready == 1'b0, "R8 busy not ready", 64'(req_ready), 64'd0);
      chk(fence_en == exp_en, "R8 busy request ignored", 64'(fence_en), 64'(exp_en));
      @(negedge clk);
    end
    req_valid = 1'b0;
    req_mask  = '0;
    wait_empty();
    chk(fence_en == exp_en, "R8 after ignored request", 64'(fence_en), 64'(exp_en));
    gap();

    // R9 back-to-back: next request taken in the pulse cycle
    dly = 0;
    do_op(1'b1, 32'h0000_4000, "R9 first of pair", 1'b0);
    do_op(1'b0, 32'h0000_4000, "R9 second of pair", 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule